// File: doc/BRIEF.md
# Soft Power Latch Sequencer

This block governs the supply of a battery instrument that is switched on by a momentary push button. A short press of the power button pulls the unit's hold line high from outside the block. As soon as it leaves reset the block drives that same line high on its own, so the supply stays up after the button is released. Driving the hold line low is the command that shuts the whole unit down.

Both buttons are active high. Each one passes through a two-flop synchronizer and a debounce filter that counts a slow tick (nominally one per millisecond). While the unit is on, a debounced press of the power button produces a one-cycle range request, and a debounced press of the mode button toggles the mode output. Any debounced button edge restarts an inactivity timer, and the timer is also held at its start while a measurement is in progress. When the timer expires, the block drops the hold line and then turns off the rail enables one step at a time. Once the hold line is low, the block ignores the buttons until the next reset.

Top module: `soft_power_latch`

## Requirements
- R1: After reset `hold_o`, `rail_a_en_o`, `rail_b_en_o` and `rail_main_en_o` are 1, `mode_o` is 0 and `range_req_o` is 0.
- R2: `hold_o` stays 1 after the power button is released, until the inactivity timer expires.
- R3: A button level that differs from its debounced state for fewer than DEBOUNCE_TICKS ticks (the counted input is the synchronized value) has no effect: no range request and no mode change.
- R4: While `hold_o` is 1, each debounced rising edge of `pwr_btn_i` makes `range_req_o` 1 for exactly one clock cycle. The debounced power state starts as pressed, so the press that powers the unit up, and its release, produce no request.
- R5: While `hold_o` is 1, each debounced rising edge of `mode_btn_i` inverts `mode_o`.
- R6: If IDLE_TICKS ticks pass after the last debounced button edge (or after reset) with `meas_busy_i` low, `hold_o` goes to 0.
- R7: While `meas_busy_i` is 1, the inactivity timer is held at its start, so `hold_o` stays 1 for as long as it is asserted and for IDLE_TICKS ticks after it falls.
- R8: Shutdown order is `hold_o`, then `rail_a_en_o`, then `rail_b_en_o`, then `rail_main_en_o` falling, each STEP_TICKS ticks after the one before.
- R9: Once `hold_o` is 0, the buttons have no effect until reset: no range request, no mode change, and `hold_o` stays 0 while the rail sequence continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time base pulse (about 1 ms) |
| pwr_btn_i | input | 1 | Power/range button, active high, asynchronous |
| mode_btn_i | input | 1 | Mode button, active high, asynchronous |
| meas_busy_i | input | 1 | High while a range measurement runs |
| hold_o | output | 1 | Supply hold line; 0 commands shutdown |
| rail_a_en_o | output | 1 | First logic rail enable |
| rail_b_en_o | output | 1 | Second rail enable |
| rail_main_en_o | output | 1 | Main logic and laser-logic rail enable |
| range_req_o | output | 1 | One-cycle range measurement request |
| mode_o | output | 1 | Current mode |

## Verification
Both buttons are swept with pulses from one clock cycle up to the longest width that still falls short of the debounce count. This separates filtering from edge detection, because none of these pulses may produce a request or a toggle, while longer presses must each produce exactly one. The inactivity timer is tested from a busy interval that lasts longer than the timeout, which shows that busy reloads the timer instead of only pausing it, and it is also tested from reset alone. Button presses during the shutdown sequence confirm that the block is locked out, and the recorded fall times of the four outputs check both their order and their spacing.

// File: rtl/soft_power_latch.sv
module soft_power_latch #(
  parameter int DEBOUNCE_TICKS = 20,
  parameter int IDLE_TICKS     = 8000,
  parameter int STEP_TICKS     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pwr_btn_i,
  input  logic mode_btn_i,
  input  logic meas_busy_i,
  output logic hold_o,
  output logic rail_a_en_o,
  output logic rail_b_en_o,
  output logic rail_main_en_o,
  output logic range_req_o,
  output logic mode_o
);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int SW = $clog2(STEP_TICKS + 1);

  typedef enum logic [2:0] {ST_ON, ST_DROP, ST_A_OFF, ST_B_OFF, ST_DONE} state_t;

  state_t state;
  logic [1:0] raw, flip, level;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] step_cnt;
  logic on, activity, expire;

  assign raw = {mode_btn_i, pwr_btn_i};

  for (genvar b = 0; b < 2; b++) begin : g_btn
    logic s1, s2, deb;
    logic [DW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        deb <= (b == 0);
        cnt <= '0;
      end else begin
        s1 <= raw[b];
        s2 <= s1;
        if (s2 == deb) cnt <= '0;
        else if (tick_i) begin
          if (cnt == DW'(DEBOUNCE_TICKS - 1)) begin
            deb <= s2;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      end
    end
    assign flip[b]  = tick_i && (s2 != deb) && (cnt == DW'(DEBOUNCE_TICKS - 1));
    assign level[b] = s2;
  end

  assign on       = (state == ST_ON);
  assign activity = |flip || meas_busy_i;
  assign expire   = on && !activity && tick_i && (idle_cnt == IW'(IDLE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (activity) idle_cnt <= '0;
    else if (on && tick_i && !expire) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ON;
      step_cnt <= '0;
    end else if (on) begin
      if (expire) state <= ST_DROP;
    end else if (state != ST_DONE && tick_i) begin
      if (step_cnt == SW'(STEP_TICKS - 1)) begin
        step_cnt <= '0;
        case (state)
          ST_DROP:  state <= ST_A_OFF;
          ST_A_OFF: state <= ST_B_OFF;
          default:  state <= ST_DONE;
        endcase
      end else step_cnt <= step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_req_o <= 1'b0;
      mode_o      <= 1'b0;
    end else begin
      range_req_o <= on && flip[0] && level[0];
      if (on && flip[1] && level[1]) mode_o <= !mode_o;
    end
  end

  assign hold_o         = on;
  assign rail_a_en_o    = (state == ST_ON) || (state == ST_DROP);
  assign rail_b_en_o    = rail_a_en_o || (state == ST_A_OFF);
  assign rail_main_en_o = (state != ST_DONE);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    range_req_o |=> !range_req_o);
  p_hold_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |=> !hold_o);
  p_no_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |=> !range_req_o);
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |=> $stable(mode_o));
  p_a_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_a_en_o) |-> !hold_o);
  p_b_after_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_b_en_o) |-> !rail_a_en_o);
  p_main_after_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_main_en_o) |-> !rail_b_en_o);
  p_busy_keeps_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && meas_busy_i) |=> hold_o);
endmodule

// File: tb/soft_power_latch_tb.sv
module soft_power_latch_tb_top;
  localparam int DB = 3, IDLE = 20, STEP = 4, TP = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pwr = 1'b1, mode_b = 1'b0, busy = 1'b0;
  logic hold, ra, rb, rm, req, mode;
  int compared = 0, mismatched = 0, req_count = 0, tick_n = 0;
  int f_hold = -1, f_a = -1, f_b = -1, f_m = -1;
  logic p_hold = 1'b1, p_a = 1'b1, p_b = 1'b1, p_m = 1'b1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  soft_power_latch #(.DEBOUNCE_TICKS(DB), .IDLE_TICKS(IDLE), .STEP_TICKS(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pwr_btn_i(pwr), .mode_btn_i(mode_b),
    .meas_busy_i(busy), .hold_o(hold), .rail_a_en_o(ra), .rail_b_en_o(rb),
    .rail_main_en_o(rm), .range_req_o(req), .mode_o(mode));

  initial forever begin
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (TP - 2) @(negedge clk);
  end

  always @(posedge clk) if (tick) tick_n <= tick_n + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      f_hold = -1; f_a = -1; f_b = -1; f_m = -1;
      p_hold = 1'b1; p_a = 1'b1; p_b = 1'b1; p_m = 1'b1;
    end else begin
      if (req) req_count++;
      if (p_hold && !hold) f_hold = tick_n;
      if (p_a && !ra) f_a = tick_n;
      if (p_b && !rb) f_b = tick_n;
      if (p_m && !rm) f_m = tick_n;
      p_hold = hold; p_a = ra; p_b = rb; p_m = rm;
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n * TP) @(negedge clk);
  endtask

  task automatic press_pwr(int cycles);
    @(negedge clk) pwr = 1'b1;
    repeat (cycles) @(negedge clk);
    pwr = 1'b0;
    wait_ticks(DB + 3);
  endtask

  task automatic press_mode(int cycles);
    @(negedge clk) mode_b = 1'b1;
    repeat (cycles) @(negedge clk);
    mode_b = 1'b0;
    wait_ticks(DB + 3);
  endtask

  task automatic do_reset(logic pwr_level);
    pwr = pwr_level;
    mode_b = 1'b0;
    busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * TP);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base;
    int mexp;
    do_reset(1'b1);
    chk("R1 hold", hold, 1);
    chk("R1 rail_a", ra, 1);
    chk("R1 rail_b", rb, 1);
    chk("R1 rail_main", rm, 1);
    chk("R1 mode", mode, 0);
    chk("R1 req", req, 0);

    wait_ticks(2);
    pwr = 1'b0;
    wait_ticks(DB + 4);
    chk("R4 no request from power-up press", req_count, 0);
    chk("R2 hold after release", hold, 1);

    busy = 1'b1;
    for (int w = 1; w <= TP * (DB - 1); w++) begin
      @(negedge clk) pwr = 1'b1;
      repeat (w - 1) @(negedge clk);
      @(negedge clk) pwr = 1'b0;
      wait_ticks(DB + 2);
      @(negedge clk) mode_b = 1'b1;
      repeat (w - 1) @(negedge clk);
      @(negedge clk) mode_b = 1'b0;
      wait_ticks(DB + 2);
    end
    chk("R3 glitch request count", req_count, 0);
    chk("R3 glitch mode", mode, 0);

    base = req_count;
    for (int k = 1; k <= 3; k++) begin
      press_pwr(TP * (DB + 2) + k);
      chk("R4 request per press", req_count - base, k);
    end
    mexp = 0;
    for (int k = 1; k <= 3; k++) begin
      press_mode(TP * (DB + 2) + 2 * k);
      mexp = mexp ^ 1;
      chk("R5 mode toggle", mode, mexp);
    end

    wait_ticks(IDLE + 10);
    chk("R7 busy keeps hold", hold, 1);
    @(negedge clk) busy = 1'b0;
    wait_ticks(IDLE - 1);
    chk("R7 hold within window after busy", hold, 1);
    chk("R2 hold before expiry", hold, 1);
    wait_ticks(2);
    chk("R6 hold dropped after idle", hold, 0);
    chk("R8 rail_a still on", ra, 1);

    base = req_count;
    press_pwr(TP * (DB + 2));
    press_mode(TP * (DB + 2));
    chk("R9 no request after drop", req_count, base);
    chk("R9 mode frozen after drop", mode, mexp);
    chk("R9 hold stays low", hold, 0);
    wait_ticks(4 * STEP);
    chk("R8 rail_main off", rm, 0);
    chk("R8 rail_b off", rb, 0);
    chk("R8 gap hold to rail_a", f_a - f_hold, STEP);
    chk("R8 gap rail_a to rail_b", f_b - f_a, STEP);
    chk("R8 gap rail_b to rail_main", f_m - f_b, STEP);

    do_reset(1'b0);
    chk("R1 hold after second reset", hold, 1);
    chk("R1 mode after second reset", mode, 0);
    chk("R1 rail_main after second reset", rm, 1);
    wait_ticks(IDLE + DB + 2);
    chk("R4 no request with button idle at reset", req_count, base);
    chk("R6 expiry from reset", hold, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule